// File: doc/BRIEF.md
# UART Interrupt Mask and Status Unit

This unit holds the interrupt bookkeeping for a serial port. Its inputs are the event lines of the receiver and transmitter, a small register write port and a register read port. A mask register decides which events are enabled. Software never writes the mask as a whole. It writes a set port, where each 1 enables a source, or a clear port, where each 1 disables one. An event on an enabled source latches into a sticky status register. Writing 1 to a status bit clears it. A single registered interrupt line is high while any bit is both pending and enabled.

The raw receiver and transmitter conditions are also sampled into a separate view. That view ignores the mask, so polling code can see conditions it has not enabled. All registers sit in a word-addressed space: 0 is the set port, 1 the clear port, 2 the mask, 3 the status and 4 the raw view. Addresses 5 to 7 read as zero. Reads are combinational on the read address.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write to address 0 sets every mask bit whose data bit is 1. Mask bits written as 0 keep their value.
- R2: A write to address 1 clears every mask bit whose data bit is 1. Mask bits written as 0 keep their value.
- R3: Addresses 0 and 1 always read as zero. The mask reads back at address 2, and a write to address 2 has no effect.
- R4: Status bit positions are 0 RX trigger, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 overrun, 6 framing error, 7 parity error and 8 RX timeout. A status bit is set at the clock edge where its event input is high and its mask bit is 1. An event on a masked-off source leaves the status unchanged.
- R5: A write to address 3 clears each status bit whose data bit is 1 and leaves the other status bits unchanged. It never sets a status bit.
- R6: If an enabled event arrives in the same cycle as a clear of that status bit, the bit stays set.
- R7: Only data bits [12:0] reach the mask and status. Bits 31:13 of a write are ignored.
- R8: `irq` is high one cycle after the AND of status and mask becomes non-zero. It falls one cycle after that AND becomes zero, whether the cause is a status clear or a mask clear.
- R9: Address 4 returns `raw_in` as it was sampled at the previous clock edge, whatever the mask holds. The raw lines never change the status.
- R10: After a synchronous reset, the mask, status and raw view are zero and `irq` is low.
- R11: Addresses 5, 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| evt_in | input | 13 | Event lines that set the status bits |
| raw_in | input | 13 | Raw channel conditions for the unmasked view |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its defaults: 13 sources and a 32-bit data port. With these values the 19 upper data bits exist, so writes with those bits set can show that they are dropped. Directed scenarios cover the following cases:
- enabling and disabling partial sets of mask bits
- events on masked and unmasked sources
- a status clear colliding with a fresh event
- the interrupt line falling when a pending source is masked off and rising again when it is re-enabled
- the raw view following its inputs while the mask is empty

// File: rtl/uart_irq_pkg.sv
// Package: register addresses and source bit positions shared by the unit.
// Assumes a word-addressed register space with a 3-bit address.
package uart_irq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_SET  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RAW  = 3'd4;

    localparam int SRC_RX_TRIG  = 0;
    localparam int SRC_RX_EMPTY = 1;
    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 3;
    localparam int SRC_TX_FULL  = 4;
    localparam int SRC_OVERRUN  = 5;
    localparam int SRC_FRAMING  = 6;
    localparam int SRC_PARITY   = 7;
    localparam int SRC_RX_TMO   = 8;
endpackage

// File: rtl/uart_irq_mask.sv
// Module: interrupt mask register.
// The mask is changed only by a write-one-to-set strobe and a
// write-one-to-clear strobe. Assumes the decoder never raises both
// strobes in the same cycle.
module uart_irq_mask #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] mask_q
);

    // Purpose: OR in the set bits, or AND out the clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (set_we)
            mask_q <= mask_q | wbits;
        else if (clr_we)
            mask_q <= mask_q & ~wbits;
    end

    p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
    p_keep_on_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));
    p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask_q & $past(wbits)) == '0));
    p_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/uart_irq_status.sv
// Module: sticky interrupt status, one flop per source.
// A masked event sets a bit. A write-one-to-clear removes it. When both
// act on the same bit in the same cycle, the event wins.
module uart_irq_status #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic         clr_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] stat_q
);

    logic [N-1:0] pass_evt;
    assign pass_evt = evt & mask;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic clr_hit;
        assign clr_hit = clr_we & wbits[i];

        // Purpose: set on a passed event, otherwise clear on a 1 write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (pass_evt[i])
                stat_q[i] <= 1'b1;
            else if (clr_hit)
                stat_q[i] <= 1'b0;
        end

        p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && !pass_evt[i]) |=> !stat_q[i]);
        p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pass_evt[i] |=> stat_q[i]);
    end

    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt & mask)) == '0));

endmodule

// File: rtl/uart_irq_readback.sv
// Module: raw condition capture and the register read multiplexer.
// Assumes DATA_W >= N. Unmapped and write-only addresses return zero.
module uart_irq_readback
    import uart_irq_pkg::*;
#(
    parameter int N      = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N-1:0]      mask,
    input  logic [N-1:0]      stat,
    input  logic [N-1:0]      raw_in,
    output logic [DATA_W-1:0] rd_data
);

    logic [N-1:0] raw_q;

    // Purpose: sample the raw channel conditions every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= raw_in;
    end

    // Purpose: select the addressed register, zero-extended.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_MASK: rd_data[N-1:0] = mask;
            ADR_STAT: rd_data[N-1:0] = stat;
            ADR_RAW:  rd_data[N-1:0] = raw_q;
            default:  rd_data = '0;
        endcase
    end

    p_raw_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (raw_q == $past(raw_in)));

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: top of the UART interrupt mask and status unit.
// Decodes register writes, instances the mask, status and readback
// blocks, and registers the interrupt request. Assumes one write at a time.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int NUM_SRC = 13,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_SRC-1:0]   evt_in,
    input  logic [NUM_SRC-1:0]   raw_in,
    output logic                 irq
);

    logic [NUM_SRC-1:0] wbits;
    logic               set_we;
    logic               clr_we;
    logic               stat_we;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_q;
    logic               irq_q;

    // Write data bits above the source count are dropped here.
    assign wbits = wr_data[NUM_SRC-1:0];

    if (DATA_W > NUM_SRC) begin : g_hi
        logic unused_hi_bits;
        assign unused_hi_bits = |wr_data[DATA_W-1:NUM_SRC];
    end

    assign set_we  = wr_en && (wr_addr == ADR_SET);
    assign clr_we  = wr_en && (wr_addr == ADR_CLR);
    assign stat_we = wr_en && (wr_addr == ADR_STAT);

    uart_irq_mask #(.N(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we),
        .clr_we (clr_we),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    uart_irq_status #(.N(NUM_SRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_in),
        .mask   (mask_q),
        .clr_we (stat_we),
        .wbits  (wbits),
        .stat_q (stat_q)
    );

    uart_irq_readback #(.N(NUM_SRC), .DATA_W(DATA_W)) u_rdbk (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .mask    (mask_q),
        .stat    (stat_q),
        .raw_in  (raw_in),
        .rd_data (rd_data)
    );

    // Purpose: glitch-free interrupt from pending-and-enabled bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(stat_q & mask_q);
    end

    assign irq = irq_q;

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & mask_q)) |=> irq);
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & mask_q)) |=> !irq);
    p_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADR_RAW && evt_in == '0) |=>
            (mask_q == $past(mask_q) && stat_q == $past(stat_q)));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
    localparam int NS = 13;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic [2:0]    rd_addr;
    logic [DW-1:0] rd_data;
    logic [NS-1:0] evt_in;
    logic [NS-1:0] raw_in;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_in(evt_in), .raw_in(raw_in), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic pulse(input logic [NS-1:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R10 mask", 3'd2, 0);
        rd_chk("R10 status", 3'd3, 0);
        rd_chk("R10 raw", 3'd4, 0);
        check("R10 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_mask;
        wr(3'd0, 32'h0A5);
        rd_chk("R1 set", 3'd2, 32'h0A5);
        wr(3'd0, 32'h100);
        rd_chk("R1 keep", 3'd2, 32'h1A5);
        wr(3'd1, 32'h005);
        rd_chk("R2 clear", 3'd2, 32'h1A0);
        rd_chk("R3 set port reads 0", 3'd0, 0);
        rd_chk("R3 clr port reads 0", 3'd1, 0);
        wr(3'd2, 32'h1FFF);
        rd_chk("R3 mask read-only", 3'd2, 32'h1A0);
    endtask

    task automatic t_wide;
        wr(3'd0, 32'hFFFF_FFFF);
        rd_chk("R7 upper set dropped", 3'd2, 32'h1FFF);
        wr(3'd1, 32'hFFFF_E000);
        rd_chk("R7 upper clr dropped", 3'd2, 32'h1FFF);
        wr(3'd1, 32'h1FFF);
        wr(3'd0, 32'h1A0);
        rd_chk("R7 restore", 3'd2, 32'h1A0);
    endtask

    task automatic t_event;
        pulse(13'h0A1);
        rd_chk("R4 masked pass", 3'd3, 32'h0A0);
        check("R8 irq not yet", {31'd0, irq}, 0);
        @(negedge clk);
        check("R8 irq rise", {31'd0, irq}, 1);
        wr(3'd3, 32'h020);
        rd_chk("R5 w1c", 3'd3, 32'h080);
        wr(3'd3, 32'h080);
        rd_chk("R5 all clear", 3'd3, 0);
        @(negedge clk);
        check("R8 irq fall", {31'd0, irq}, 0);
        pulse(13'h100);
        @(negedge clk);
        check("R8 irq pending", {31'd0, irq}, 1);
        wr(3'd1, 32'h100);
        @(negedge clk);
        check("R8 mask off drops irq", {31'd0, irq}, 0);
        rd_chk("R8 status held", 3'd3, 32'h100);
        wr(3'd0, 32'h100);
        @(negedge clk);
        check("R8 re-enable raises irq", {31'd0, irq}, 1);
        wr(3'd3, 32'h100);
    endtask

    task automatic t_same;
        pulse(13'h020);
        rd_chk("R6 pre", 3'd3, 32'h020);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h020; evt_in = 13'h020;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; evt_in = '0;
        rd_chk("R6 event wins", 3'd3, 32'h020);
        wr(3'd3, 32'h020);
        rd_chk("R6 cleared after", 3'd3, 0);
    endtask

    task automatic t_raw;
        wr(3'd1, 32'h1FFF);
        @(negedge clk);
        raw_in = 13'h01A;
        @(negedge clk);
        rd_chk("R9 raw view", 3'd4, 32'h01A);
        rd_chk("R9 status untouched", 3'd3, 0);
        raw_in = 13'h008;
        rd_chk("R9 raw is sampled", 3'd4, 32'h01A);
        @(negedge clk);
        rd_chk("R9 raw follows", 3'd4, 32'h008);
        raw_in = '0;
    endtask

    task automatic t_unmapped;
        wr(3'd0, 32'h0F0);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'h1FFF);
            rd_chk("R11 reads 0", 3'(a), 0);
        end
        rd_chk("R11 mask unchanged", 3'd2, 32'h0F0);
        rd_chk("R11 status unchanged", 3'd3, 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; evt_in = '0; raw_in = '0;
        t_reset;
        t_mask;
        t_wide;
        t_event;
        t_same;
        t_raw;
        t_unmapped;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule